// File: doc/BRIEF.md
# CPU to USB FIFO Bridge

This block sits between a synchronous 8-bit processor bus and an external parallel USB FIFO device. The device has one 8-bit data bus, an active-low read strobe, an active-high write strobe and two active-low status flags. It has no chip select. The bridge decodes two registers: a data register and a status register. A processor read of the data register produces a timed read pulse toward the device. A processor write of the data register produces a timed write pulse. A read of the status register returns both flags after they pass through a synchronizer.

A bus access is accepted only in a clock cycle in which the phase-2 style enable and the block select are both high. Data-register accesses take several clocks. During that time `bus_busy` is high, and further requests are dropped. Every accepted access ends with a one-cycle `bus_done`; on reads, `bus_rdata` is valid in that cycle. The device-side data bus is modelled as separate input, output and output-enable signals. The bridge drives the output only around a write pulse.

Top module: `cpu_fifo_bridge`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `fifo_rd_n` is 1, `fifo_wr` is 0, `fifo_dout_oe` is 0, `bus_busy` is 0 and `bus_done` is 0.
- R2: A data-register read (`bus_reg`=0, `bus_rnw`=1) is accepted at a clock edge. From that same edge, `fifo_rd_n` is driven low for exactly RD_CYCLES clocks. No write pulse occurs during the access.
- R3: `bus_rdata` holds the value of `fifo_din` sampled at the edge where `fifo_rd_n` returns high. `bus_done` is high for the single cycle that follows that edge.
- R4: A data-register write (`bus_reg`=0, `bus_rnw`=0) sets `fifo_dout_oe` and `fifo_dout`=`bus_wdata` one clock before `fifo_wr` rises. `fifo_wr` then stays high for exactly WR_CYCLES clocks, and `fifo_dout_oe` stays high for that whole time.
- R5: After `fifo_wr` falls, `fifo_dout` is held unchanged and `fifo_dout_oe` stays high for one more clock. `fifo_dout_oe` is then released, and `bus_done` is high in that same cycle.
- R6: `fifo_dout_oe` is never high while `fifo_rd_n` is low, and the two strobes are never active together.
- R7: A status read (`bus_reg`=1, `bus_rnw`=1) produces no strobe. In the cycle after acceptance it returns `bus_done`=1 and `bus_rdata` = {6'b0, rx flag on bit 1, tx flag on bit 0}. Each flag is the raw active-low level of `fifo_rx_avail_n` / `fifo_tx_room_n` after SYNC_STAGES synchronizer flops.
- R8: A status-register write produces one `bus_done` cycle. It creates no read pulse, no write pulse and no `fifo_dout_oe` cycle.
- R9: A request is accepted only when `bus_en` and `bus_sel` are both high and no access is in progress. Requests that arrive while `bus_busy` is high are dropped and produce no strobe and no `bus_done`.
- R10: `bus_busy` is high from the edge that accepts a data-register access until the edge that raises `bus_done`. A strobe is only ever active while `bus_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Phase-2 style bus cycle qualifier |
| bus_sel | input | 1 | Address decode hit for this block |
| bus_reg | input | 1 | Register select: 0 data, 1 status |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, valid with bus_done |
| bus_done | output | 1 | One-cycle completion of an accepted access |
| bus_busy | output | 1 | A data-register access is in progress |
| fifo_din | input | 8 | Data bus value driven by the device |
| fifo_dout | output | 8 | Data toward the device |
| fifo_dout_oe | output | 1 | Output enable for fifo_dout |
| fifo_rd_n | output | 1 | Read strobe, active low |
| fifo_wr | output | 1 | Write strobe, active high, commits on falling edge |
| fifo_rx_avail_n | input | 1 | Low when receive data is waiting |
| fifo_tx_room_n | input | 1 | Low when the device can accept a byte |

## Verification
A sequencer stuck in the wrong state shows up at the device pins within one clock. Examples are a strobe that is active without `bus_busy`, output enable overlapping the read pulse, or a pulse that ends one clock early or late. Such errors are measured by counting strobe widths against RD_CYCLES and WR_CYCLES. A capture register loaded at the wrong edge, or a data register that changes before the write falls, is seen at `bus_done` or at the write's falling edge. At that point the scoreboard compares the returned or driven byte against the one queued by the driver. Synchronizer depth errors appear as stale status bytes once the flags have settled.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int BYTE_W     = 8;
    localparam int RX_FLAG_BIT = 1;
    localparam int TX_FLAG_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LOW,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } bridge_state_e;

    typedef struct packed {
        logic              is_read;
        logic              is_status;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic rx_n, input logic tx_n);
        logic [BYTE_W-1:0] b;
        b              = '0;
        b[RX_FLAG_BIT] = rx_n;
        b[TX_FLAG_BIT] = tx_n;
        return b;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bridge_flag_sync.sv
module bridge_flag_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= {WIDTH{RESET_VAL}};
            end else begin
                if (g == 0) chain[g] <= async_in;
                else        chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/bridge_pulse_timer.sv
module bridge_pulse_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
#(
    parameter int RD_CYCLES = 3,
    parameter int WR_CYCLES = 4,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  bus_req_t          req,
    input  logic              rx_n_s,
    input  logic              tx_n_s,
    input  logic [BYTE_W-1:0] fifo_din,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              rd_n,
    output logic              wr,
    output logic              oe,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] rdata,
    output logic              done,
    output logic              busy
);

    bridge_state_e st_q, st_d;
    logic          accept_idle;
    logic          status_rd_go;
    logic          status_any_go;
    logic          data_wr_go;
    logic          rd_finish;

    assign accept_idle   = req_valid && (st_q == ST_IDLE);
    assign status_any_go = accept_idle && req.is_status;
    assign status_rd_go  = status_any_go && req.is_read;
    assign data_wr_go    = accept_idle && !req.is_status && !req.is_read;
    assign rd_finish     = (st_q == ST_RD_LOW) && tmr_expired;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept_idle && !req.is_status) begin
                    if (req.is_read) begin
                        st_d     = ST_RD_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYCLES - 1);
                    end else begin
                        st_d = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_LOW: begin
                if (tmr_expired) st_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                st_d     = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_CYCLES - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_expired) st_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            rd_n  <= 1'b1;
            wr    <= 1'b0;
            oe    <= 1'b0;
            dout  <= '0;
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            st_q <= st_d;
            rd_n <= (st_d != ST_RD_LOW);
            wr   <= (st_d == ST_WR_PULSE);
            oe   <= (st_d == ST_WR_SETUP) || (st_d == ST_WR_PULSE) || (st_d == ST_WR_HOLD);
            if (data_wr_go) begin
                dout <= req.wdata;
            end
            if (status_rd_go) begin
                rdata <= pack_status(rx_n_s, tx_n_s);
            end else if (rd_finish) begin
                rdata <= fifo_din;
            end
            done <= status_any_go || rd_finish || (st_q == ST_WR_HOLD);
        end
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/cpu_fifo_bridge.sv
module cpu_fifo_bridge
    import bridge_pkg::*;
#(
    parameter int RD_CYCLES   = 3,
    parameter int WR_CYCLES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_sel,
    input  logic              bus_reg,
    input  logic              bus_rnw,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_done,
    output logic              bus_busy,
    input  logic [BYTE_W-1:0] fifo_din,
    output logic [BYTE_W-1:0] fifo_dout,
    output logic              fifo_dout_oe,
    output logic              fifo_rd_n,
    output logic              fifo_wr,
    input  logic              fifo_rx_avail_n,
    input  logic              fifo_tx_room_n
);

    localparam int MAX_CYC = max2(RD_CYCLES, WR_CYCLES);
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    bus_req_t          req;
    logic              req_valid;
    logic [1:0]        flags_s;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;

    assign req_valid     = bus_en && bus_sel;
    assign req.is_read   = bus_rnw;
    assign req.is_status = bus_reg;
    assign req.wdata     = bus_wdata;

    bridge_flag_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_flag_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({fifo_rx_avail_n, fifo_tx_room_n}),
        .sync_out (flags_s)
    );

    bridge_pulse_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    bridge_seq #(
        .RD_CYCLES (RD_CYCLES),
        .WR_CYCLES (WR_CYCLES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req         (req),
        .rx_n_s      (flags_s[1]),
        .tx_n_s      (flags_s[0]),
        .fifo_din    (fifo_din),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .rd_n        (fifo_rd_n),
        .wr          (fifo_wr),
        .oe          (fifo_dout_oe),
        .dout        (fifo_dout),
        .rdata       (bus_rdata),
        .done        (bus_done),
        .busy        (bus_busy)
    );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int RD_CYCLES = 3,
    parameter int WR_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       fifo_rd_n,
    input logic       fifo_wr,
    input logic       fifo_dout_oe,
    input logic [7:0] fifo_dout,
    input logic       bus_done,
    input logic       bus_busy
);

    localparam int CW = $clog2(RD_CYCLES + WR_CYCLES + 4);

    logic [CW-1:0] rd_lo_cnt;
    logic [CW-1:0] wr_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_lo_cnt <= '0;
            wr_hi_cnt <= '0;
        end else begin
            rd_lo_cnt <= fifo_rd_n ? '0 : rd_lo_cnt + 1'b1;
            wr_hi_cnt <= fifo_wr   ? wr_hi_cnt + 1'b1 : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (fifo_rd_n && !fifo_wr && !fifo_dout_oe && !bus_done)); // R1

    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_rd_n) |-> (rd_lo_cnt == CW'(RD_CYCLES))); // R2

    AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> fifo_dout_oe); // R4

    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_wr) |-> (wr_hi_cnt == CW'(WR_CYCLES))); // R4

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_wr) |-> (fifo_dout_oe && $stable(fifo_dout))); // R5

    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fifo_dout_oe && $past(fifo_dout_oe)) |-> $stable(fifo_dout)); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_n |-> !fifo_dout_oe); // R6

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_wr && !fifo_rd_n)); // R6

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> bus_done); // R10

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!fifo_rd_n || fifo_wr) |-> bus_busy); // R10

endmodule

bind cpu_fifo_bridge bridge_checker #(
    .RD_CYCLES (RD_CYCLES),
    .WR_CYCLES (WR_CYCLES)
) u_bridge_checker (
    .clk          (clk),
    .rst          (rst),
    .fifo_rd_n    (fifo_rd_n),
    .fifo_wr      (fifo_wr),
    .fifo_dout_oe (fifo_dout_oe),
    .fifo_dout    (fifo_dout),
    .bus_done     (bus_done),
    .bus_busy     (bus_busy)
);

// File: tb/test_cpu_fifo_bridge.sv
`timescale 1ns/1ps
module test_cpu_fifo_bridge;

    localparam int RD_CYC = 3;
    localparam int WR_CYC = 4;
    localparam int SYNC_N = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0, bus_sel = 1'b0, bus_reg = 1'b0, bus_rnw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_done, bus_busy;
    logic [7:0] fifo_din, fifo_dout;
    logic       fifo_dout_oe, fifo_rd_n, fifo_wr;
    logic       rx_n = 1'b1, tx_n = 1'b1;
    logic [7:0] rx_byte = 8'h00;

    always #10 clk = ~clk;

    // device model: drives its byte only while the read strobe is low
    assign fifo_din = fifo_rd_n ? 8'hEE : rx_byte;

    cpu_fifo_bridge #(
        .RD_CYCLES (RD_CYC),
        .WR_CYCLES (WR_CYC),
        .SYNC_STAGES (SYNC_N)
    ) i_cpu_fifo_bridge (
        .clk (clk), .rst (rst),
        .bus_en (bus_en), .bus_sel (bus_sel), .bus_reg (bus_reg), .bus_rnw (bus_rnw),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_done (bus_done), .bus_busy (bus_busy),
        .fifo_din (fifo_din), .fifo_dout (fifo_dout), .fifo_dout_oe (fifo_dout_oe),
        .fifo_rd_n (fifo_rd_n), .fifo_wr (fifo_wr),
        .fifo_rx_avail_n (rx_n), .fifo_tx_room_n (tx_n)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    typedef struct { bit rd; logic [7:0] data; string tag; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] wr_q[$];

    // monitor state
    int   done_cnt = 0, rd_pulses = 0, wr_pulses = 0, oe_cycles = 0;
    int   lo_cnt = 0, hi_cnt = 0;
    bit   contention = 0, hold_chk = 0;
    logic prev_rd_n = 1'b1, prev_wr = 1'b0, prev_oe = 1'b0;
    logic [7:0] prev_do = 8'h00, cur_wexp = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_dout_oe) oe_cycles++;
            if (hold_chk) begin
                check(!fifo_dout_oe, "R5 oe released after hold", fifo_dout_oe, 0);
                hold_chk = 0;
            end
            if (!fifo_rd_n) begin
                lo_cnt++;
                if (fifo_dout_oe || fifo_wr) contention = 1;
            end else if (!prev_rd_n) begin
                check(lo_cnt == RD_CYC, "R2 read pulse width", lo_cnt, RD_CYC);
                check(!contention, "R6 no drive during read", contention, 0);
                rd_pulses++; lo_cnt = 0; contention = 0;
            end
            if (fifo_wr && !prev_wr) begin
                cur_wexp = (wr_q.size() > 0) ? wr_q.pop_front() : 8'hXX;
                check(prev_oe && !prev_wr && prev_do === cur_wexp, "R4 data set up before write",
                      {prev_oe, prev_do}, {1'b1, cur_wexp});
            end
            if (fifo_wr) hi_cnt++;
            if (!fifo_wr && prev_wr) begin
                check(hi_cnt == WR_CYC, "R4 write pulse width", hi_cnt, WR_CYC);
                check(fifo_dout_oe && fifo_dout === cur_wexp, "R5 data held after fall",
                      {fifo_dout_oe, fifo_dout}, {1'b1, cur_wexp});
                wr_pulses++; hi_cnt = 0; hold_chk = 1;
            end
            if (bus_done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.rd) check(bus_rdata === e.data, e.tag, bus_rdata, e.data);
                end
            end
            prev_rd_n = fifo_rd_n; prev_wr = fifo_wr; prev_oe = fifo_dout_oe; prev_do = fifo_dout;
        end
    end

    // driver: queues the expected result, issues the access, waits for done
    task automatic access(input bit reg_s, input bit rnw, input logic [7:0] wd,
                          input logic [7:0] exp, input string tag);
        exp_t e;
        e.rd = rnw; e.data = exp; e.tag = tag;
        exp_q.push_back(e);
        if (!reg_s && !rnw) wr_q.push_back(wd);
        @(negedge clk);
        bus_en = 1; bus_sel = 1; bus_reg = reg_s; bus_rnw = rnw; bus_wdata = wd;
        @(negedge clk);
        bus_en = 0; bus_sel = 0;
        if (!reg_s) check(bus_busy, "R10 busy after accept", bus_busy, 1);
        for (int i = 0; i < 50 && !bus_done; i++) @(negedge clk);
        check(bus_done && !bus_busy, "R10 idle at done", {bus_done, bus_busy}, 2'b10);
    endtask

    task automatic set_flags(input logic r, input logic t);
        @(negedge clk);
        rx_n = r; tx_n = t;
        repeat (SYNC_N + 2) @(negedge clk);
    endtask

    initial begin
        int d0, r0, w0, o0;
        repeat (3) @(negedge clk);
        check(fifo_rd_n && !fifo_wr && !fifo_dout_oe && !bus_busy && !bus_done, "R1 in reset",
              {fifo_rd_n, fifo_wr, fifo_dout_oe, bus_busy, bus_done}, 5'b10000);
        rst = 0;
        @(negedge clk);
        check(fifo_rd_n && !fifo_wr && !fifo_dout_oe && !bus_busy && !bus_done, "R1 after reset",
              {fifo_rd_n, fifo_wr, fifo_dout_oe, bus_busy, bus_done}, 5'b10000);

        // R9: enable without select does nothing
        bus_en = 1; bus_sel = 0; bus_rnw = 1; bus_reg = 0;
        @(negedge clk); bus_en = 0;
        repeat (4) @(negedge clk);
        check(done_cnt == 0 && rd_pulses == 0 && !bus_busy, "R9 unselected ignored", done_cnt + rd_pulses, 0);
        // R9: select without enable does nothing
        bus_en = 0; bus_sel = 1;
        @(negedge clk); bus_sel = 0;
        repeat (4) @(negedge clk);
        check(done_cnt == 0 && rd_pulses == 0, "R9 no enable ignored", done_cnt + rd_pulses, 0);

        // R2 R3: data reads with several patterns
        rx_byte = 8'h5A; access(0, 1, 8'h00, 8'h5A, "R3 read data 5A");
        rx_byte = 8'hA5; access(0, 1, 8'h00, 8'hA5, "R3 read data A5");
        rx_byte = 8'h00; access(0, 1, 8'h00, 8'h00, "R3 read data 00");
        rx_byte = 8'hFF; access(0, 1, 8'h00, 8'hFF, "R3 read data FF");

        // R4 R5: data writes
        access(0, 0, 8'h3C, 8'h00, "R4 write");
        access(0, 0, 8'hC3, 8'h00, "R4 write");
        access(0, 0, 8'h81, 8'h00, "R4 write");

        // R7: status for each flag combination
        set_flags(1, 0); access(1, 1, 8'h00, 8'h02, "R7 status rx empty tx room");
        set_flags(0, 1); access(1, 1, 8'h00, 8'h01, "R7 status rx data tx full");
        set_flags(0, 0); access(1, 1, 8'h00, 8'h00, "R7 status both active");
        set_flags(1, 1); access(1, 1, 8'h00, 8'h03, "R7 status both idle");

        // R8: status write has no device effect
        r0 = rd_pulses; w0 = wr_pulses; o0 = oe_cycles;
        access(1, 0, 8'hFF, 8'h00, "R8 status write");
        repeat (4) @(negedge clk);
        check(rd_pulses == r0 && wr_pulses == w0 && oe_cycles == o0, "R8 no strobe on status write",
              (rd_pulses - r0) + (wr_pulses - w0) + (oe_cycles - o0), 0);

        // R9: request while busy is dropped
        d0 = done_cnt; w0 = wr_pulses;
        rx_byte = 8'h77;
        begin
            exp_t e;
            e.rd = 1; e.data = 8'h77; e.tag = "R3 read under busy";
            exp_q.push_back(e);
        end
        @(negedge clk);
        bus_en = 1; bus_sel = 1; bus_reg = 0; bus_rnw = 1;
        @(negedge clk);
        bus_en = 0; bus_sel = 0;
        @(negedge clk);
        bus_en = 1; bus_sel = 1; bus_reg = 0; bus_rnw = 0; bus_wdata = 8'h99;
        @(negedge clk);
        bus_en = 0; bus_sel = 0;
        repeat (RD_CYC + WR_CYC + 6) @(negedge clk);
        check(done_cnt == d0 + 1 && wr_pulses == w0, "R9 busy request dropped",
              {done_cnt - d0, wr_pulses - w0}, 2);

        // back-to-back write then read
        access(0, 0, 8'h42, 8'h00, "R5 write before read");
        rx_byte = 8'h24; access(0, 1, 8'h00, 8'h24, "R3 read after write");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && wr_q.size() == 0, "R3 all results seen", exp_q.size() + wr_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule